// File: doc/BRIEF.md
# Sign-Magnitude Difference Unit

This combinational block takes two unsigned operands of a parameterised width and returns their difference as a sign flag plus an unsigned magnitude. Two ripple-borrow subtractor chains, each made of single-bit subtractor cells, run side by side: one forms a minus b and the other forms b minus a. The borrow that leaves the top cell of the first chain tells whether a is smaller than b. That borrow is the sign output, and it also selects which of the two chains supplies the magnitude.

The block fits wherever a distance between two counts or codes is needed, with its direction kept apart from its size. Because the sign comes straight from a borrow, equal operands give a positive zero and a negative zero never appears.

Top module: `smag_diff`

## Requirements
- R1: Each cell of a chain produces a difference bit equal to the XOR of its minuend bit, its subtrahend bit and its incoming borrow.
- R2: Each cell produces an outgoing borrow that is 1 when at least two of these hold: the minuend bit is 0, the subtrahend bit is 1, the incoming borrow is 1 (with the minuend-bit-0 term paired with either of the others).
- R3: Borrows ripple from bit 0 upward, and the borrow into bit 0 of both chains is 0.
- R4: `neg_o` equals 1 exactly when `a_i` is less than `b_i` taken as unsigned numbers.
- R5: When `neg_o` is 0, `mag_o` equals `a_i - b_i`; when `neg_o` is 1, `mag_o` equals `b_i - a_i`. In both cases `mag_o` equals the absolute difference.
- R6: When `a_i` equals `b_i`, `neg_o` is 0 and `mag_o` is 0.
- R7: The width W is a parameter; the outputs follow the inputs with no clock and no stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | W | Minuend, unsigned |
| b_i | input | W | Subtrahend, unsigned |
| neg_o | output | 1 | 1 when a_i is less than b_i |
| mag_o | output | W | Absolute value of a_i minus b_i |

## Verification
At the default width of 4 every operand pair is applied, so each borrow path through every cell is driven. Equal pairs show that no negative zero can appear. Pairs that differ by one and pairs of zero and all ones expose an error in the top borrow or in the selection. A second instance at width 16 receives seeded random pairs plus the same extremes, which catches borrow-chain faults that show up only on longer ripple paths.

// File: rtl/smag_diff.sv
module smag_diff #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         neg_o,
  output logic [W-1:0] mag_o
);

  logic [W:0]   brw_ab, brw_ba;
  logic [W-1:0] dif_ab, dif_ba;

  assign brw_ab[0] = 1'b0;  // R3
  assign brw_ba[0] = 1'b0;

  for (genvar k = 0; k < W; k++) begin : g_cell
    // R1 difference bit, R2 borrow out
    assign dif_ab[k]   = a_i[k] ^ b_i[k] ^ brw_ab[k];
    assign brw_ab[k+1] = (~a_i[k] & b_i[k]) | (~a_i[k] & brw_ab[k]) | (b_i[k] & brw_ab[k]);
    assign dif_ba[k]   = b_i[k] ^ a_i[k] ^ brw_ba[k];
    assign brw_ba[k+1] = (~b_i[k] & a_i[k]) | (~b_i[k] & brw_ba[k]) | (a_i[k] & brw_ba[k]);
  end

  assign neg_o = brw_ab[W];
  assign mag_o = neg_o ? dif_ba : dif_ab;

  always_comb begin
    assert_sign_R4: assert (neg_o == (a_i < b_i));
    assert_mag_R5:  assert (mag_o == (neg_o ? b_i - a_i : a_i - b_i));
    assert_zero_R6: assert (!(a_i == b_i) || (!neg_o && mag_o == '0));
    assert_chains_R3: assert (!(a_i != b_i) || (brw_ab[W] ^ brw_ba[W]));
  end

endmodule

// File: tb/smag_diff_tb_top.sv
module smag_diff_tb_top;
  localparam int WS = 4;
  localparam int WL = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [WS-1:0] a_s, b_s, m_s;
  logic          n_s;
  logic [WL-1:0] a_l, b_l, m_l;
  logic          n_l;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  smag_diff #(.W(WS)) dut_i (.a_i(a_s), .b_i(b_s), .neg_o(n_s), .mag_o(m_s));
  smag_diff #(.W(WL)) dut_l (.a_i(a_l), .b_i(b_l), .neg_o(n_l), .mag_o(m_l));

  function automatic int ref_abs(int x, int y);
    return (x < y) ? y - x : x - y;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic try_s(int x, int y);
    a_s = WS'(x); b_s = WS'(y);
    @(negedge clk);
    chk((x < y) ? "R4 sign (R2 borrow)" : "R4 sign (R3 chain)", int'(n_s), int'(x < y));
    chk(x == y ? "R6 zero" : "R5 mag (R1 bits)", int'(m_s), ref_abs(x, y));
  endtask

  task automatic try_l(int x, int y);
    a_l = WL'(x); b_l = WL'(y);
    @(negedge clk);
    chk("R7 wide sign R4", int'(n_l), int'(x < y));
    chk("R7 wide mag R5", int'(m_l), ref_abs(x, y));
  endtask

  initial begin
    int mx;
    a_s = '0; b_s = '0; a_l = '0; b_l = '0;
    void'($urandom(32'd1234));
    @(negedge clk);
    chk("R6 idle zero", int'({n_s, m_s}), 0);
    for (int x = 0; x < (1 << WS); x++)
      for (int y = 0; y < (1 << WS); y++)
        try_s(x, y);
    mx = (1 << WL) - 1;
    try_l(0, mx); try_l(mx, 0); try_l(mx, mx); try_l(0, 0);
    try_l(1, 2); try_l(2, 1); try_l(32768, 32767); try_l(32767, 32768);
    for (int k = 0; k < 500; k++) try_l(int'($urandom % 65536), int'($urandom % 65536));
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule